// File: doc/BRIEF.md
# Store Lane Aligner with Whole-Word Register Capture

This block sits between a CPU's store stage and a 32-bit on-die peripheral bus. Each store request carries a store class (full word, byte, halfword, store-word-left, store-word-right), a two-bit byte offset within the word and a 32-bit source operand. The block moves the source bytes onto the lanes the store class and offset select, derives the byte enables, and drives a one-cycle bus write in the cycle after the request.

Misaligned requests are rejected. A halfword at an odd offset and a full word at a non-zero offset both raise an address-error pulse instead of a write. The bus is not strobed, and no enables are raised.

The block also holds one 32-bit memory-mapped register on that bus. This register does not honour byte enables. Any accepted store captures the entire lane-shifted bus word, so a byte or halfword store replaces every bit, including bits whose enables were low. Its contents are always visible on a combinational readback port. Reset clears the register to zero.

Top module: `stlane_top`

## Requirements
- R1: While reset is held and after it is released with no request, `busWrite` and `addrErr` are 0, `busByteEn` is 4'b0000 and `regValue` is 0.
- R2: A word store (`reqOp`=0) at offset 0 drives `busData` equal to the source and `busByteEn`=4'b1111 in the cycle after the request.
- R3: A byte store (`reqOp`=1) at offset N drives the source shifted left by 8*N bits and enables only lane N (bit N of `busByteEn`).
- R4: A halfword store (`reqOp`=2) at offset 0 drives the source unchanged with enables 4'b0011. At offset 2 it drives the source shifted left by 16 with enables 4'b1100.
- R5: A store-word-left (`reqOp`=3) at offset N drives the source shifted right by 8*(3-N) bits and enables lanes 0 through N.
- R6: A store-word-right (`reqOp`=4) at offset N drives the source shifted left by 8*N bits and enables lanes N through 3.
- R7: The register is overwritten with the whole `busData` word at the clock edge that ends a `busWrite` cycle, whatever the enables are. It is unchanged in every other cycle. `regValue` shows it combinationally.
- R8: An accepted store produces `busWrite` high for exactly one cycle, the cycle after the request, with at least one enable set.
- R9: A halfword at offset 1 or 3, or a word at a non-zero offset, produces a one-cycle `addrErr` pulse in the cycle after the request. In that cycle `busWrite` is low and `busByteEn` is 0, and the register keeps its value.
- R10: With `reqValid` low, or with `reqOp` of 5, 6 or 7, no write and no error occur, and the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Store request present this cycle |
| reqOp | input | 3 | Store class: 0 word, 1 byte, 2 halfword, 3 store-left, 4 store-right |
| reqOffset | input | 2 | Byte offset within the addressed word |
| reqSrc | input | 32 | Source register value |
| busData | output | 32 | Lane-shifted word driven on the bus |
| busByteEn | output | 4 | Byte enables, bit N for lane N |
| busWrite | output | 1 | One-cycle write strobe |
| addrErr | output | 1 | One-cycle address-error-on-store pulse |
| regValue | output | 32 | Combinational readback of the captured register |

## Verification
On every cycle, the assertions check the following:
- write and error never coincide;
- an error carries no enables and a write carries some;
- the register takes the whole previous bus word after each write and holds otherwise;
- misaligned halfwords always produce the error pulse;
- aligned word stores pass through unchanged.

The lane placement of byte, halfword, left and right stores at every offset needs the bench's scenarios, which compare data and enables against independently computed values. So does the overwriting of a non-zero baseline by a partial store, and the silence of unknown store classes.

// File: rtl/stlane_pkg.sv
package stlane_pkg;

  typedef enum logic [2:0] {
    OP_WORD  = 3'd0,
    OP_BYTE  = 3'd1,
    OP_HALF  = 3'd2,
    OP_LEFT  = 3'd3,
    OP_RIGHT = 3'd4
  } storeOp_e;

  localparam int unsigned OP_LAST = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadBus;    // capture lane-shifted word and enables this edge
    logic commitReg;  // bus write in progress: register takes the bus word
  } laneStrobes_t;

endpackage

// File: rtl/stlane_control.sv
module stlane_control
  import stlane_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqOp,
  input  logic [OFF_W-1:0] reqOffset,
  output laneStrobes_t     strobes,
  output logic             busWrite,
  output logic             addrErr
);

  logic knownOp;
  logic misaligned;
  logic acceptNow;
  logic faultNow;

  always_comb begin
    knownOp    = (32'(reqOp) <= OP_LAST);
    misaligned = 1'b0;
    case (storeOp_e'(reqOp))
      OP_WORD: misaligned = (reqOffset != '0);
      OP_HALF: misaligned = reqOffset[0];
      default: misaligned = 1'b0;
    endcase
    acceptNow = reqValid && knownOp && !misaligned;
    faultNow  = reqValid && knownOp && misaligned;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busWrite <= 1'b0;
      addrErr  <= 1'b0;
    end else begin
      busWrite <= acceptNow;
      addrErr  <= faultNow;
    end
  end

  always_comb begin
    strobes.loadBus   = acceptNow;
    strobes.commitReg = busWrite;
  end

endmodule

// File: rtl/stlane_datapath.sv
module stlane_datapath
  import stlane_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(LANES),
  localparam int unsigned SHIFT_W = OFF_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobes_t      strobes,
  input  logic [2:0]        reqOp,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [DATA_W-1:0] reqSrc,
  output logic [DATA_W-1:0] busData,
  output logic [LANES-1:0]  busByteEn,
  output logic [DATA_W-1:0] regValue
);

  logic [SHIFT_W-1:0] upBits;
  logic [SHIFT_W-1:0] downBits;
  logic [OFF_W-1:0]   downLanes;
  logic [DATA_W-1:0]  laneUp;
  logic [DATA_W-1:0]  laneDown;
  logic [DATA_W-1:0]  nextData;
  logic [LANES-1:0]   nextEn;
  logic [DATA_W-1:0]  mmioReg;

  // Lane shifters
  always_comb begin
    upBits    = {reqOffset, 3'b000};
    downLanes = OFF_W'(LANES - 1) - reqOffset;
    downBits  = {downLanes, 3'b000};
    laneUp    = reqSrc << upBits;
    laneDown  = reqSrc >> downBits;
    case (storeOp_e'(reqOp))
      OP_WORD:  nextData = reqSrc;
      OP_BYTE:  nextData = laneUp;
      OP_HALF:  nextData = laneUp;
      OP_LEFT:  nextData = laneDown;
      OP_RIGHT: nextData = laneUp;
      default:  nextData = '0;
    endcase
  end

  // Per-lane enable decode
  for (genvar lane = 0; lane < LANES; lane++) begin : gLaneEn
    localparam logic [OFF_W-1:0] LANE_IDX = OFF_W'(lane);
    always_comb begin
      case (storeOp_e'(reqOp))
        OP_WORD:  nextEn[lane] = 1'b1;
        OP_BYTE:  nextEn[lane] = (LANE_IDX == reqOffset);
        OP_HALF:  nextEn[lane] = (LANE_IDX[OFF_W-1:1] == reqOffset[OFF_W-1:1]);
        OP_LEFT:  nextEn[lane] = (LANE_IDX <= reqOffset);
        OP_RIGHT: nextEn[lane] = (LANE_IDX >= reqOffset);
        default:  nextEn[lane] = 1'b0;
      endcase
    end
  end

  // Bus stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busData   <= '0;
      busByteEn <= '0;
    end else if (strobes.loadBus) begin
      busData   <= nextData;
      busByteEn <= nextEn;
    end else begin
      busData   <= '0;
      busByteEn <= '0;
    end
  end

  // Register ignores byte enables: whole word is captured
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mmioReg <= '0;
    end else if (strobes.commitReg) begin
      mmioReg <= busData;
    end
  end

  assign regValue = mmioReg;

endmodule

// File: rtl/stlane_top.sv
module stlane_top
  import stlane_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [DATA_W-1:0] reqSrc,
  output logic [DATA_W-1:0] busData,
  output logic [LANES-1:0]  busByteEn,
  output logic              busWrite,
  output logic              addrErr,
  output logic [DATA_W-1:0] regValue
);

  laneStrobes_t strobes;

  stlane_control #(.LANES(LANES)) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .reqOffset (reqOffset),
    .strobes   (strobes),
    .busWrite  (busWrite),
    .addrErr   (addrErr)
  );

  stlane_datapath #(.DATA_W(DATA_W)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqOp     (reqOp),
    .reqOffset (reqOffset),
    .reqSrc    (reqSrc),
    .busData   (busData),
    .busByteEn (busByteEn),
    .regValue  (regValue)
  );

endmodule

// File: rtl/stlane_checker.sv
module stlane_checker #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        reqOp,
  input logic [OFF_W-1:0]  reqOffset,
  input logic [DATA_W-1:0] reqSrc,
  input logic [DATA_W-1:0] busData,
  input logic [LANES-1:0]  busByteEn,
  input logic              busWrite,
  input logic              addrErr,
  input logic [DATA_W-1:0] regValue
);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrite && addrErr));

  assert_err_no_enables_R9: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> busByteEn == '0);

  assert_write_has_enables_R8: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |-> busByteEn != '0);

  assert_overwrite_R7: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |=> regValue == $past(busData));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busWrite |=> $stable(regValue));

  assert_misaligned_half_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'd2 && reqOffset[0]) |=> (addrErr && !busWrite));

  assert_word_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'd0 && reqOffset == '0)
      |=> (busWrite && busByteEn == '1 && busData == $past(reqSrc)));

endmodule

bind stlane_top stlane_checker #(.DATA_W(DATA_W)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqOp     (reqOp),
  .reqOffset (reqOffset),
  .reqSrc    (reqSrc),
  .busData   (busData),
  .busByteEn (busByteEn),
  .busWrite  (busWrite),
  .addrErr   (addrErr),
  .regValue  (regValue)
);

// File: tb/stlane_top_test.sv
`timescale 1ns/1ps
module stlane_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = 3'd0;
  logic [1:0]  reqOffset = 2'd0;
  logic [31:0] reqSrc = 32'd0;
  logic [31:0] busData;
  logic [3:0]  busByteEn;
  logic        busWrite;
  logic        addrErr;
  logic [31:0] regValue;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] expReg = 32'd0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stlane_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqOffset(reqOffset), .reqSrc(reqSrc), .busData(busData),
    .busByteEn(busByteEn), .busWrite(busWrite), .addrErr(addrErr),
    .regValue(regValue)
  );

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R10";
    endcase
  endfunction

  function automatic bit expFault(input logic [2:0] op, input logic [1:0] off);
    if (op == 3'd0) return off != 2'd0;
    if (op == 3'd2) return off[0];
    return 1'b0;
  endfunction

  function automatic logic [31:0] expData(input logic [2:0] op, input logic [1:0] off,
                                          input logic [31:0] src);
    case (op)
      3'd0: return src;
      3'd1: return src << (8 * off);
      3'd2: return (off == 2'd0) ? src : (src << 16);
      3'd3: return src >> (8 * (3 - off));
      3'd4: return src << (8 * off);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [3:0] expEn(input logic [2:0] op, input logic [1:0] off);
    case (op)
      3'd0: return 4'b1111;
      3'd1: return 4'b0001 << off;
      3'd2: return (off == 2'd0) ? 4'b0011 : 4'b1100;
      3'd3: return (4'b0010 << off) - 4'd1;
      3'd4: return 4'b1111 << off;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check32(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] want);
    compared++;
    if (got !== want) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, want);
    end
  endtask

  // One request; checks the bus cycle and then the register
  task automatic doStore(input bit valid, input logic [2:0] op, input logic [1:0] off,
                         input logic [31:0] src);
    bit accept, fault;
    string tag;
    accept = valid && (op <= 3'd4) && !expFault(op, off);
    fault  = valid && (op <= 3'd4) && expFault(op, off);
    tag = fault ? "R9" : (valid ? opTag(op) : "R10");
    @(negedge clk);
    reqValid = valid; reqOp = op; reqOffset = off; reqSrc = src;
    @(posedge clk); #1;
    reqValid = 1'b0;
    check32(accept ? "R8" : tag, "busWrite", {31'd0, busWrite}, {31'd0, accept});
    check32(tag, "addrErr", {31'd0, addrErr}, {31'd0, fault});
    check32(tag, "busByteEn", {28'd0, busByteEn},
            {28'd0, accept ? expEn(op, off) : 4'b0000});
    if (accept) begin
      check32(tag, "busData", busData, expData(op, off, src));
      expReg = expData(op, off, src);
    end
    @(posedge clk); #1;
    check32(accept ? "R7" : tag, "regValue", regValue, expReg);
    check32("R8", "busWrite single cycle", {31'd0, busWrite}, 32'd0);
    check32("R9", "addrErr single cycle", {31'd0, addrErr}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check32("R1", "busWrite in reset", {31'd0, busWrite}, 32'd0);
    check32("R1", "regValue in reset", regValue, 32'd0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check32("R1", "addrErr after reset", {31'd0, addrErr}, 32'd0);
    check32("R1", "busByteEn after reset", {28'd0, busByteEn}, 32'd0);

    // Directed: every class at every offset over a non-zero baseline
    for (int op = 0; op < 8; op++) begin
      for (int off = 0; off < 4; off++) begin
        doStore(1'b1, 3'd0, 2'd0, 32'h11223344);   // baseline, R2
        doStore(1'b1, 3'(op), 2'(off), 32'hAABBCCDD);
      end
    end
    // R7: byte store over all-ones must clear every other lane
    doStore(1'b1, 3'd0, 2'd0, 32'hFFFFFFFF);
    doStore(1'b1, 3'd1, 2'd0, 32'hAABBCCDD);
    check32("R7", "byte over ones", regValue, 32'hAABBCCDD);
    doStore(1'b1, 3'd0, 2'd0, 32'hFFFFFFFF);
    doStore(1'b1, 3'd3, 2'd0, 32'hAABBCCDD);
    check32("R7", "left over ones", regValue, 32'h000000AA);
    // R9: misaligned halfword keeps the register
    doStore(1'b1, 3'd2, 2'd3, 32'h01020304);
    check32("R9", "held after fault", regValue, 32'h000000AA);
    // R10: idle request with legal-looking fields
    doStore(1'b0, 3'd0, 2'd0, 32'h55555555);
    check32("R10", "idle keeps reg", regValue, 32'h000000AA);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      doStore(($urandom % 8) != 0, 3'($urandom % 8), 2'($urandom % 4), $urandom);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule